// File: doc/BRIEF.md
# Six-Phase Video Strobe Generator

This block turns the two-phase horizontal clock of a column-sampled display into six staggered sample-and-hold strobes. The display captures six parallel video channels on one shared clock edge, so each channel first passes through an external analog sample-and-hold stage. Each stage is fired by its own strobe. Spreading the six strobes evenly across one horizontal clock period lets the external stages line the channels up in phase before the display takes them all at once.

Everything runs on a reference clock whose rate is `DIV` times the horizontal clock rate, where `DIV` is a multiple of six. The rising edge of the first horizontal phase starts each period. A line-start pulse opens an active window that lasts `win_len` horizontal periods, and it also captures the scan direction for the whole line. In right scan, strobe 1 comes first and strobe 6 comes last. In left scan the channel order is reversed, so the channel order always follows the direction of the column shift register.

Top module: `video_strobe_gen`

## Requirements
- R1: While reset is high, and on the cycle after reset is released, all six strobe outputs are low.
- R2: In an active period, slot k (k = 0..5) produces a pulse exactly one reference cycle wide. Take the reference edge that first samples `hclk_a` high as edge 0. The pulse for slot k is high from edge k*DIV/6+1 until the next edge.
- R3: When the captured direction is high (right scan), slot k drives `strobe[k]`. Bit 0 is ck1 and bit 5 is ck6, so the strobes fire in the order ck1, ck2, …, ck6.
- R4: When the captured direction is low (left scan), slot k drives `strobe[5-k]`, so the strobes fire in the order ck6, ck5, …, ck1.
- R5: At no cycle is more than one strobe high.
- R6: `dir_right` is sampled only in a cycle where `line_start` is high. A change of `dir_right` at any other time does not alter the strobe order until the next line start.
- R7: After a line start, strobes appear in exactly the first `win_len` horizontal periods, counted from the first `hclk_a` rising edge after the pulse. Later periods give no strobes, and `win_len` = 0 gives none at all.
- R8: If `line_start` falls in the same cycle as an `hclk_a` rising edge, that period gives no strobes. The window of `win_len` periods then begins at the next rising edge.
- R9: Slots 0 to 2 fire only while `hclk_a` is high, and slots 3 to 5 fire only while `hclk_b` is high. A slot whose phase is low at its time stays silent.
- R10: Each rising edge of `hclk_a` produces at most one burst of six slots. If the horizontal clock stalls, the strobes stay low, and the window count is not used up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, DIV times the horizontal clock rate |
| rst | input | 1 | Synchronous active-high reset |
| hclk_a | input | 1 | First horizontal clock phase; its rising edge starts a period |
| hclk_b | input | 1 | Second horizontal clock phase, complement of hclk_a |
| line_start | input | 1 | One-cycle marker that opens the active window and captures direction |
| dir_right | input | 1 | Scan direction: high for right scan, low for left scan |
| win_len | input | WIN_W | Number of horizontal periods in the active window |
| strobe | output | 6 | Sample strobes; bit 0 is ck1 and bit 5 is ck6 |

## Verification
The main collision tested is a line start that arrives in the same reference cycle as a rising edge of `hclk_a`. In that cycle the window reload competes with the start of a period. The bench raises both inputs together and checks that the period they share gives no strobes. It also checks that the next `win_len` periods give full bursts in the newly captured order. A second overlap is a direction change in the middle of a line, which arrives while strobes are being produced. The bench expects the old order to hold until the next line start.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
  localparam int NUM_STROBES = 6;
  localparam int HALF_SLOTS  = NUM_STROBES / 2;

  // Map a time slot to an output bit for the captured direction.
  function automatic int slot_to_bit(input int slot, input logic right);
    return right ? slot : (NUM_STROBES - 1 - slot);
  endfunction
endpackage

// File: rtl/hclk_edge.sv
module hclk_edge (
  input  logic clk,
  input  logic rst,
  input  logic hclk_a,
  output logic rise
);
  logic a_q;

  always_ff @(posedge clk) begin
    if (rst) a_q <= 1'b0;
    else     a_q <= hclk_a;
  end

  assign rise = hclk_a & ~a_q;
endmodule

// File: rtl/line_window.sv
module line_window #(
  parameter int WIN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start,
  input  logic             dir_right,
  input  logic [WIN_W-1:0] win_len,
  input  logic             rise,
  output logic             period_go,
  output logic             dir_q
);
  logic [WIN_W-1:0] remaining;

  // A line start takes priority over a coincident period edge.
  assign period_go = rise & ~line_start & (remaining != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
      dir_q     <= 1'b1;
    end else if (line_start) begin
      remaining <= win_len;
      dir_q     <= dir_right;
    end else if (period_go) begin
      remaining <= remaining - 1'b1;
    end
  end
endmodule

// File: rtl/phase_gen.sv
module phase_gen #(
  parameter int DIV = 12,
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort,
  input  logic          go,
  output logic [PW-1:0] phase,
  output logic          run
);
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      run   <= 1'b0;
    end else if (abort) begin
      run   <= 1'b0;
    end else if (go) begin
      phase <= '0;
      run   <= 1'b1;
    end else if (run) begin
      if (phase == LAST) run <= 1'b0;
      else               phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/strobe_map.sv
module strobe_map
  import strobe_pkg::*;
#(
  parameter int DIV = 12,
  localparam int PW   = (DIV > 1) ? $clog2(DIV) : 1,
  localparam int SLOT = DIV / NUM_STROBES
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [PW-1:0]          phase,
  input  logic                   run,
  input  logic                   dir_q,
  input  logic                   hclk_a,
  input  logic                   hclk_b,
  output logic [NUM_STROBES-1:0] strobe
);
  logic [NUM_STROBES-1:0] hit;
  logic [NUM_STROBES-1:0] next_strobe;

  genvar k;
  generate
    for (k = 0; k < NUM_STROBES; k++) begin : g_slot
      if (k < HALF_SLOTS) begin : g_first
        assign hit[k] = run & hclk_a & (phase == PW'(k * SLOT));
      end else begin : g_second
        assign hit[k] = run & hclk_b & (phase == PW'(k * SLOT));
      end
    end
  endgenerate

  always_comb begin
    next_strobe = '0;
    for (int s = 0; s < NUM_STROBES; s++) begin
      if (hit[s]) next_strobe[slot_to_bit(s, dir_q)] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) strobe <= '0;
    else     strobe <= next_strobe;
  end
endmodule

// File: rtl/video_strobe_gen.sv
module video_strobe_gen
  import strobe_pkg::*;
#(
  parameter int DIV   = 12,
  parameter int WIN_W = 12,
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   hclk_a,
  input  logic                   hclk_b,
  input  logic                   line_start,
  input  logic                   dir_right,
  input  logic [WIN_W-1:0]       win_len,
  output logic [NUM_STROBES-1:0] strobe
);
  logic          rise;
  logic          period_go;
  logic          dir_q;
  logic [PW-1:0] phase;
  logic          run;

  hclk_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .hclk_a (hclk_a),
    .rise   (rise)
  );

  line_window #(.WIN_W(WIN_W)) u_win (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .dir_right  (dir_right),
    .win_len    (win_len),
    .rise       (rise),
    .period_go  (period_go),
    .dir_q      (dir_q)
  );

  phase_gen #(.DIV(DIV)) u_phase (
    .clk   (clk),
    .rst   (rst),
    .abort (line_start),
    .go    (period_go),
    .phase (phase),
    .run   (run)
  );

  strobe_map #(.DIV(DIV)) u_map (
    .clk    (clk),
    .rst    (rst),
    .phase  (phase),
    .run    (run),
    .dir_q  (dir_q),
    .hclk_a (hclk_a),
    .hclk_b (hclk_b),
    .strobe (strobe)
  );
endmodule

// File: rtl/strobe_chk.sv
module strobe_chk #(
  parameter int NS = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          hclk_a,
  input logic          hclk_b,
  input logic          line_start,
  input logic [NS-1:0] strobe
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (strobe == '0));

  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(strobe));

  // R8
  line_start_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    line_start |=> ##1 (strobe == '0));

  // R9
  phase_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe != '0) |-> ($past(hclk_a) || $past(hclk_b)));

  genvar i;
  generate
    for (i = 0; i < NS; i++) begin : g_width
      // R2
      single_width_chk: assert property (@(posedge clk) disable iff (rst)
        strobe[i] |=> !strobe[i]);
    end
  endgenerate
endmodule

bind video_strobe_gen strobe_chk #(.NS(6)) u_strobe_chk (
  .clk        (clk),
  .rst        (rst),
  .hclk_a     (hclk_a),
  .hclk_b     (hclk_b),
  .line_start (line_start),
  .strobe     (strobe)
);

// File: tb/sim_video_strobe_gen.sv
module sim_video_strobe_gen;
  localparam int DIV   = 12;
  localparam int WIN_W = 12;
  localparam int S     = DIV / 6;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             hclk_a = 1'b0;
  logic             hclk_b = 1'b1;
  logic             line_start = 1'b0;
  logic             dir_right = 1'b1;
  logic [WIN_W-1:0] win_len = '0;
  logic [5:0]       strobe;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  video_strobe_gen #(.DIV(DIV), .WIN_W(WIN_W)) u0 (
    .clk(clk), .rst(rst), .hclk_a(hclk_a), .hclk_b(hclk_b),
    .line_start(line_start), .dir_right(dir_right),
    .win_len(win_len), .strobe(strobe)
  );

  task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: strobe=%b expected=%b at %0t", req, got, exp, $time);
    end
    checks++;
    if ($countones(got) > 1) begin
      fails++;
      $display("FAIL R5: strobe=%b expected at most one bit high", got);
    end
  endtask

  function automatic logic [5:0] expv(input logic act, input logic right,
                                      input logic bad_b, input int c);
    logic [5:0] v = '0;
    for (int k = 0; k < 6; k++)
      if (act && c == k * S + 1 && !(bad_b && k >= 3))
        v[right ? k : 5 - k] = 1'b1;
    return v;
  endfunction

  // Called at a falling edge; drives one full horizontal period.
  task automatic run_period(input string req, input logic act, input logic right,
                            input logic bad_b, input logic ls_now);
    hclk_a = 1'b1;
    hclk_b = 1'b0;
    if (ls_now) line_start = 1'b1;
    for (int c = 0; c < DIV; c++) begin
      if (c == DIV / 2) begin
        hclk_a = 1'b0;
        hclk_b = bad_b ? 1'b0 : 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      line_start = 1'b0;
      check(req, strobe, expv(act, right, bad_b, c));
    end
    hclk_b = 1'b1;
  endtask

  task automatic new_line(input logic d, input int w);
    line_start = 1'b1;
    dir_right  = d;
    win_len    = WIN_W'(w);
    @(posedge clk);
    @(negedge clk);
    line_start = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", strobe, 6'b0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1", strobe, 6'b0);
  endtask

  task automatic t_right();
    new_line(1'b1, 2);
    run_period("R3", 1'b1, 1'b1, 1'b0, 1'b0);
    run_period("R2", 1'b1, 1'b1, 1'b0, 1'b0);
    run_period("R7", 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_left();
    new_line(1'b0, 2);
    run_period("R4", 1'b1, 1'b0, 1'b0, 1'b0);
    run_period("R4", 1'b1, 1'b0, 1'b0, 1'b0);
    run_period("R7", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_dir_midline();
    new_line(1'b1, 3);
    run_period("R6", 1'b1, 1'b1, 1'b0, 1'b0);
    dir_right = 1'b0;
    run_period("R6", 1'b1, 1'b1, 1'b0, 1'b0);
    run_period("R6", 1'b1, 1'b1, 1'b0, 1'b0);
    new_line(1'b0, 1);
    run_period("R6", 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_zero_window();
    new_line(1'b1, 0);
    run_period("R7", 1'b0, 1'b1, 1'b0, 1'b0);
    run_period("R7", 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_coincide();
    dir_right = 1'b0;
    win_len   = WIN_W'(2);
    run_period("R8", 1'b0, 1'b0, 1'b0, 1'b1);
    run_period("R8", 1'b1, 1'b0, 1'b0, 1'b0);
    run_period("R8", 1'b1, 1'b0, 1'b0, 1'b0);
    run_period("R8", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_phase_gate();
    new_line(1'b1, 2);
    run_period("R9", 1'b1, 1'b1, 1'b1, 1'b0);
    new_line(1'b0, 1);
    run_period("R9", 1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_stall();
    new_line(1'b1, 2);
    run_period("R10", 1'b1, 1'b1, 1'b0, 1'b0);
    hclk_a = 1'b0;
    hclk_b = 1'b0;
    repeat (3 * DIV) begin
      @(posedge clk);
      @(negedge clk);
      check("R10", strobe, 6'b0);
    end
    run_period("R10", 1'b1, 1'b1, 1'b0, 1'b0);
    run_period("R10", 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_right();
    t_left();
    t_dir_midline();
    t_zero_window();
    t_coincide();
    t_phase_gate();
    t_stall();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule